// File: doc/BRIEF.md
# Byte Memory Parity Generate/Check Path

This block sits between a bidirectional byte-wide data bus and a memory that keeps one parity bit beside every stored byte. A single odd-parity tree with nine inputs serves both directions. On a write, the tree sees the byte on the bus and a ninth input held at zero, so its output is the bit to store that gives the 9-bit word an even count of ones. On a read, the block drives the stored byte onto the bus and feeds the stored parity bit into the ninth input. A tree output of one then means the word came back with odd parity, and the block flags it.

The read and write strobes choose the operation. The block drives the bus only during a read. When neither strobe is asserted, or when both are asserted, the bus is left to other drivers and the error flag stays low. Address decoding and the memory's own timing belong elsewhere.

Top module: `bp_parity_path`

## Requirements
- R1: With only `wr` asserted, `mem_pin` equals the XOR of the eight bits on `data_bus`, so the 9-bit word {`mem_pin`, `mem_din`} holds an even number of ones.
- R2: `mem_din` always carries the byte currently present on `data_bus`.
- R3: With only `wr` asserted, the level of `mem_pout` has no effect on `mem_pin`.
- R4: With only `rd` asserted, the block drives `mem_dout` onto `data_bus`.
- R5: With only `rd` asserted, `error` is 1 exactly when the 9-bit word {`mem_pout`, `mem_dout`} has an odd number of ones.
- R6: With `rd` low, the block does not drive `data_bus`, so a value placed on the bus by another driver reaches `mem_din` unchanged.
- R7: With `rd` low, `error` is 0 whatever `mem_dout` and `mem_pout` hold.
- R8: With `rd` and `wr` both asserted, the block does not drive `data_bus` and holds `error` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| data_bus | inout | 8 | Shared bidirectional data bus |
| mem_din | output | 8 | Byte presented to the memory for storing |
| mem_pin | output | 1 | Parity bit presented to the memory for storing |
| mem_dout | input | 8 | Byte read out of the memory |
| mem_pout | input | 1 | Parity bit read out of the memory |
| error | output | 1 | High when a read returns a word with odd parity |

## Verification
All 256 byte values are written through the block into a small memory model in the bench, and each stored parity bit is compared with a bit count done in the bench. The writes are made with both levels on the stored-parity input, which shows whether that input leaks into the tree. Each byte is then read back three ways: intact, with its parity bit flipped, and with one data bit flipped. This separates a correct check from a flag that is stuck, ignores the parity bit, or ignores the data. Idle and both-strobe cycles use memory words with odd parity, while the bench drives a byte on the bus that differs from the memory output, which reveals any leaked flag or any driving of the bus by the block.

// File: rtl/bp_parity_pkg.sv
package bp_parity_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_CLASH = 2'b11
    } bus_op_e;

    typedef struct packed {
        logic drive_bus;
        logic gate_stored;
        logic flag_en;
    } path_ctrl_t;

    function automatic path_ctrl_t ctrl_for(input bus_op_e op);
        path_ctrl_t c;
        c = '0;
        if (op == OP_READ) begin
            c.drive_bus   = 1'b1;
            c.gate_stored = 1'b1;
            c.flag_en     = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/bp_op_decode.sv
module bp_op_decode
    import bp_parity_pkg::*;
(
    input  logic       rd_i,
    input  logic       wr_i,
    output bus_op_e    op_o,
    output path_ctrl_t ctrl_o
);

    always_comb begin
        unique case ({rd_i, wr_i})
            2'b10:   op_o = OP_READ;
            2'b01:   op_o = OP_WRITE;
            2'b11:   op_o = OP_CLASH;
            default: op_o = OP_IDLE;
        endcase
        ctrl_o = ctrl_for(op_o);
    end

    always_comb begin
        if (wr_i) begin
            AST_NO_DRIVE_ON_WRITE: assert (!ctrl_o.drive_bus); // R8
        end
        if (!rd_i) begin
            AST_NO_FLAG_WITHOUT_READ: assert (!ctrl_o.flag_en); // R7
        end
    end

endmodule

// File: rtl/bp_parity_tree.sv
module bp_parity_tree #(
    parameter int N_IN = 9
) (
    input  logic [N_IN-1:0] bits_i,
    output logic            odd_o
);

    localparam int LEVELS = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int PADDED = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        localparam int NW = PADDED >> l;
        logic [NW-1:0] v;
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < NW; k++) begin : g_bit
                if (k < N_IN) begin : g_real
                    assign v[k] = bits_i[k];
                end else begin : g_pad
                    assign v[k] = 1'b0;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < NW; k++) begin : g_xor
                assign v[k] = g_lvl[l-1].v[2*k] ^ g_lvl[l-1].v[2*k+1];
            end
        end
    end

    assign odd_o = g_lvl[LEVELS].v[0];

    always_comb begin
        AST_TREE_MATCHES_COUNT: assert (odd_o == ($countones(bits_i) % 2 == 1)); // R1
    end

endmodule

// File: rtl/bp_bus_port.sv
module bp_bus_port #(
    parameter int W = 8
) (
    inout  wire  [W-1:0] bus_io,
    input  logic         drive_i,
    input  logic [W-1:0] out_data_i,
    output logic [W-1:0] in_data_o
);

    assign bus_io    = drive_i ? out_data_i : {W{1'bz}};
    assign in_data_o = bus_io;

endmodule

// File: rtl/bp_parity_path.sv
module bp_parity_path
    import bp_parity_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              rd,
    input  logic              wr,
    inout  wire  [DATA_W-1:0] data_bus,
    output logic [DATA_W-1:0] mem_din,
    output logic              mem_pin,
    input  logic [DATA_W-1:0] mem_dout,
    input  logic              mem_pout,
    output logic              error
);

    localparam int TREE_N = DATA_W + 1;

    bus_op_e          op;
    path_ctrl_t       ctrl;
    logic [DATA_W-1:0] bus_seen;
    logic              ninth;
    logic              tree_odd;

    bp_op_decode u_decode (
        .rd_i   (rd),
        .wr_i   (wr),
        .op_o   (op),
        .ctrl_o (ctrl)
    );

    bp_bus_port #(.W(DATA_W)) u_port (
        .bus_io     (data_bus),
        .drive_i    (ctrl.drive_bus),
        .out_data_i (mem_dout),
        .in_data_o  (bus_seen)
    );

    assign ninth = mem_pout & ctrl.gate_stored;

    bp_parity_tree #(.N_IN(TREE_N)) u_tree (
        .bits_i ({ninth, bus_seen}),
        .odd_o  (tree_odd)
    );

    assign mem_din = bus_seen;
    assign mem_pin = tree_odd;
    assign error   = ctrl.flag_en & tree_odd;

    always_comb begin
        if (op == OP_READ) begin
            AST_READ_DRIVES_BUS: assert (bus_seen == mem_dout); // R4
            AST_READ_FLAG: assert (error == (($countones({mem_pout, mem_dout}) % 2) == 1)); // R5
        end
        if (op == OP_WRITE) begin
            AST_WRITE_EVEN_WORD: assert (($countones({mem_pin, mem_din}) % 2) == 0); // R1
        end
        if (op == OP_CLASH) begin
            AST_CLASH_QUIET: assert (!error); // R8
        end
        if (!rd) begin
            AST_IDLE_QUIET: assert (!error); // R7
        end
    end

endmodule

// File: tb/bp_parity_path_tb.sv
module bp_parity_path_tb;

    localparam int W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rd, wr;
    logic         tb_en;
    logic [W-1:0] tb_drv;
    wire  [W-1:0] data_bus;
    logic [W-1:0] mem_din;
    logic         mem_pin;
    logic [W-1:0] mem_dout;
    logic         mem_pout;
    logic         error;

    assign data_bus = tb_en ? tb_drv : {W{1'bz}};

    bp_parity_path u_dut (
        .rd       (rd),
        .wr       (wr),
        .data_bus (data_bus),
        .mem_din  (mem_din),
        .mem_pin  (mem_pin),
        .mem_dout (mem_dout),
        .mem_pout (mem_pout),
        .error    (error)
    );

    logic [W:0] mem_arr [0:255];

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    function automatic logic odd_of(input logic [W:0] v);
        int c;
        c = 0;
        for (int i = 0; i <= W; i++) c += v[i];
        return logic'(c % 2);
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic r, input logic w, input logic en, input logic [W-1:0] d,
                         input logic [W-1:0] md, input logic mp);
        @(negedge clk);
        rd = r; wr = w; tb_en = en; tb_drv = d; mem_dout = md; mem_pout = mp;
        #2;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (wr && !rd) mem_arr[mem_din] <= {mem_pin, mem_din};
    end

    initial begin
        rd = 0; wr = 0; tb_en = 0; tb_drv = '0; mem_dout = '0; mem_pout = 0;
        for (int a = 0; a < 256; a++) mem_arr[a] = '0;

        // reset/idle state: no flag with an odd word presented
        apply(0, 0, 1, 8'h5a, 8'h01, 1'b0);
        check("R7 idle flag", {8'h0, error}, 9'h0);
        check("R6 idle bus", {1'b0, mem_din}, {1'b0, 8'h5a});

        // write sweep with both stored-parity levels
        for (int b = 0; b < 256; b++) begin
            apply(0, 1, 1, W'(b), ~W'(b), 1'b1);
            check("R1 write parity", {8'h0, mem_pin}, {8'h0, odd_of({1'b0, W'(b)})});
            check("R2 write data", {1'b0, mem_din}, {1'b0, W'(b)});
            check("R7 write flag", {8'h0, error}, 9'h0);
            apply(0, 1, 1, W'(b), ~W'(b), 1'b0);
            check("R3 pout ignored", {8'h0, mem_pin}, {8'h0, odd_of({1'b0, W'(b)})});
            @(posedge clk);
            #1;
            check("R1 stored even", {8'h0, odd_of(mem_arr[b])}, 9'h0);
        end

        // read sweep: intact, parity flipped, data bit flipped
        for (int b = 0; b < 256; b++) begin
            logic [W:0] word;
            word = mem_arr[b];
            apply(1, 0, 0, 8'h00, word[W-1:0], word[W]);
            check("R4 read bus", {1'b0, data_bus}, {1'b0, W'(b)});
            check("R5 read clean", {8'h0, error}, 9'h0);
            apply(1, 0, 0, 8'h00, word[W-1:0], ~word[W]);
            check("R5 parity flip", {8'h0, error}, 9'h1);
            apply(1, 0, 0, 8'h00, word[W-1:0] ^ W'(1 << (b % W)), word[W]);
            check("R5 data flip", {8'h0, error}, 9'h1);
            check("R4 read bus flip", {1'b0, data_bus}, {1'b0, W'(b) ^ W'(1 << (b % W))});
        end

        // idle and clash with odd words and a foreign driver on the bus
        for (int b = 0; b < 256; b += 17) begin
            apply(0, 0, 1, W'(b), ~W'(b), ~odd_of({1'b0, ~W'(b)}));
            check("R7 idle odd word", {8'h0, error}, 9'h0);
            check("R6 idle no drive", {1'b0, data_bus}, {1'b0, W'(b)});
            apply(1, 1, 1, W'(b), ~W'(b), ~odd_of({1'b0, ~W'(b)}));
            check("R8 clash flag", {8'h0, error}, 9'h0);
            check("R8 clash no drive", {1'b0, mem_din}, {1'b0, W'(b)});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule